// File: doc/BRIEF.md
# ADC Controller Register Bank

This block is the software-visible configuration store of a sixteen-channel analog-to-digital conversion engine. A word-wide bus writes and reads it. The bank holds these registers:

- an engine control word, whose fields also drive the engine directly;
- three full-width control words for interrupts, detection and clocking;
- eight packed channel-result words;
- sixteen limit words and sixteen hysteresis words;
- an interrupt-source word and a trim word.

Each register group keeps only its own defined bits. The engine control word also rewrites two of its bits on every write.

Every read strobe is answered one cycle later with a one-cycle valid pulse and the data. A read of a channel-result word also sends a request pulse and the word index to a neighbouring sampling block. That block owns the side effects of consuming a sample. The bank does no conversion, no analog control and no clock division.

Top module: `adcreg_bank`

## Requirements
- R1: After a synchronous reset, the words at byte offsets 0x08 and 0x0C read 0x0000000F and every other mapped word reads 0. `bus_rvalid` and `samp_req` are low.
- R2: `bus_rvalid` is high in exactly the cycle after each cycle in which `bus_rd` is high, and `bus_rdata` is valid in that cycle. Whenever `bus_rvalid` is low, `bus_rdata` is 0.
- R3: A write to offset 0x00 stores bit 8 equal to written bit 0, whatever value is written to bit 8.
- R4: A write to offset 0x00 always stores bit 5 as 0. The other written bits are stored unchanged.
- R5: The stored engine word drives three outputs: `eng_on` is bit 0, `eng_mode` is bits 3:1 (0 off, 1 standby, 7 normal), and `chan_en` is bits 31:16.
- R6: Offsets 0x04, 0x08 and 0x0C store and return all 32 written bits.
- R7: Offsets 0x10 to 0x2C are channel words with index (offset-0x10)>>2. A write keeps only the bits under mask 0x03FF03FF.
- R8: Offsets 0x30 to 0x6C are limit words with index (offset-0x30)>>2. A write keeps only the bits under mask 0x03FF03FF.
- R9: Offsets 0x70 to 0xAC are hysteresis words with index (offset-0x70)>>2. A write keeps only the bits under mask 0x83FF03FF.
- R10: Offset 0xC0 keeps bits 15:0 of a write, and offset 0xC4 keeps bits 3:0.
- R11: Any other offset is unmapped, including an offset whose two low bits are nonzero. A read of it returns 0, and a write to it changes no register.
- R12: A read of a channel word raises `samp_req` for one cycle, together with `bus_rvalid`, with `samp_idx` equal to the channel word index. `samp_req` stays low for every other access.
- R13: When a read and a write to the same word occur in the same cycle, the read returns the contents from before the write. The write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| bus_wr | input | 1 | write strobe |
| bus_rd | input | 1 | read strobe |
| bus_addr | input | 12 | byte offset in the register window |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | read data valid, one cycle after bus_rd |
| samp_req | output | 1 | channel word consumed, pulse to the sampling block |
| samp_idx | output | 3 | index of the channel word that was read |
| eng_on | output | 1 | engine enable field |
| eng_mode | output | 3 | engine operating mode field |
| chan_en | output | 16 | per-channel enable field |

## Verification
A read and a write can land in the same cycle, either on the same word or on different words. The bench forces this by raising both strobes on one clock edge. The target is sometimes a single word and sometimes an engine-control or array word. Each collision is judged twice: the returned data must equal the model's contents from before the write, and a follow-up read must show the newly masked value. Randomly mixed reads and writes, including misaligned and out-of-window offsets, are checked against a bench model after every read.

// File: rtl/adcreg_pkg.sv
`timescale 1ns/1ps
package adcreg_pkg;
  localparam int unsigned OFF_ENG   = 'h00;
  localparam int unsigned OFF_IRQC  = 'h04;
  localparam int unsigned OFF_DET   = 'h08;
  localparam int unsigned OFF_CLKC  = 'h0C;
  localparam int unsigned BASE_CHAN = 'h10;
  localparam int unsigned BASE_BND  = 'h30;
  localparam int unsigned BASE_HYS  = 'h70;
  localparam int unsigned OFF_ISRC  = 'hC0;
  localparam int unsigned OFF_TRIM  = 'hC4;

  localparam logic [31:0] MASK_PAIR = 32'h03FF_03FF;
  localparam logic [31:0] MASK_HYS  = 32'h83FF_03FF;
  localparam logic [31:0] MASK_ISRC = 32'h0000_FFFF;
  localparam logic [31:0] MASK_TRIM = 32'h0000_000F;
  localparam logic [31:0] RST_DET   = 32'h0000_000F;
  localparam logic [31:0] RST_CLKC  = 32'h0000_000F;

  localparam int ENG_EN_BIT    = 0;
  localparam int ENG_ACOMP_BIT = 5;
  localparam int ENG_INIT_BIT  = 8;

  typedef enum logic [3:0] {
    G_NONE, G_ENG, G_IRQC, G_DET, G_CLKC, G_CHAN, G_BND, G_HYS, G_ISRC, G_TRIM
  } grp_e;

  function automatic logic [31:0] eng_wr_value(logic [31:0] w);
    logic [31:0] v;
    v = w;
    v[ENG_ACOMP_BIT] = 1'b0;
    v[ENG_INIT_BIT]  = w[ENG_EN_BIT];
    return v;
  endfunction
endpackage

// File: rtl/adcreg_decode.sv
`timescale 1ns/1ps
module adcreg_decode
  import adcreg_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NUM_CH = 16,
  parameter int IDX_W  = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output grp_e              grp,
  output logic [IDX_W-1:0]  idx
);
  localparam int unsigned CH_WORDS  = NUM_CH / 2;
  localparam int unsigned BND_WORDS = NUM_CH;
  localparam int unsigned HYS_WORDS = NUM_CH;

  logic [31:0] off;

  always_comb begin
    off = 32'(addr);
    grp = G_NONE;
    idx = '0;
    if (off[1:0] == 2'b00) begin
      if (off == OFF_ENG)       grp = G_ENG;
      else if (off == OFF_IRQC) grp = G_IRQC;
      else if (off == OFF_DET)  grp = G_DET;
      else if (off == OFF_CLKC) grp = G_CLKC;
      else if (off == OFF_ISRC) grp = G_ISRC;
      else if (off == OFF_TRIM) grp = G_TRIM;
      else if (off >= BASE_CHAN && off < BASE_CHAN + 4 * CH_WORDS) begin
        grp = G_CHAN;
        idx = IDX_W'((off - BASE_CHAN) >> 2);
      end else if (off >= BASE_BND && off < BASE_BND + 4 * BND_WORDS) begin
        grp = G_BND;
        idx = IDX_W'((off - BASE_BND) >> 2);
      end else if (off >= BASE_HYS && off < BASE_HYS + 4 * HYS_WORDS) begin
        grp = G_HYS;
        idx = IDX_W'((off - BASE_HYS) >> 2);
      end
    end
  end
endmodule

// File: rtl/adcreg_wordarray.sv
`timescale 1ns/1ps
module adcreg_wordarray #(
  parameter int          DEPTH  = 16,
  parameter int          DATA_W = 32,
  parameter logic [31:0] MASK   = 32'hFFFF_FFFF
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] idx,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rdata_q
);
  localparam logic [DATA_W-1:0] KEEP = DATA_W'(MASK);

  logic [DATA_W-1:0] mem [DEPTH];

  // registered read of the pre-write contents, single write port
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      rdata_q <= mem[idx];
      if (we) mem[idx] <= wdata & KEEP;
    end
  end

  // R7 R8 R9: no bit outside the group mask is ever stored
  p_mask_kept_r7: assert property (@(posedge clk) disable iff (rst)
    we |=> ((mem[$past(idx)] & ~KEEP) == '0));
  // R13: a read in the write cycle returns the old word
  p_read_old_r13: assert property (@(posedge clk) disable iff (rst)
    we |=> (rdata_q == $past(mem[idx])));
endmodule

// File: rtl/adcreg_ctlregs.sv
`timescale 1ns/1ps
module adcreg_ctlregs
  import adcreg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        we,
  input  grp_e        grp,
  input  logic [31:0] wdata,
  output logic [31:0] eng_q,
  output logic [31:0] irqc_q,
  output logic [31:0] det_q,
  output logic [31:0] clkc_q,
  output logic [31:0] isrc_q,
  output logic [31:0] trim_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      eng_q  <= '0;
      irqc_q <= '0;
      det_q  <= RST_DET;
      clkc_q <= RST_CLKC;
      isrc_q <= '0;
      trim_q <= '0;
    end else if (we) begin
      case (grp)
        G_ENG:   eng_q  <= eng_wr_value(wdata);
        G_IRQC:  irqc_q <= wdata;
        G_DET:   det_q  <= wdata;
        G_CLKC:  clkc_q <= wdata;
        G_ISRC:  isrc_q <= wdata & MASK_ISRC;
        G_TRIM:  trim_q <= wdata & MASK_TRIM;
        default: ;
      endcase
    end
  end

  p_init_copy_r3: assert property (@(posedge clk) disable iff (rst)
    (we && grp == G_ENG) |=> (eng_q[ENG_INIT_BIT] == $past(wdata[ENG_EN_BIT])));
  p_acomp_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (we && grp == G_ENG) |=> !eng_q[ENG_ACOMP_BIT]);
  p_trim_width_r10: assert property (@(posedge clk) disable iff (rst)
    (we && grp == G_TRIM) |=> (trim_q[31:4] == '0));
  p_nomap_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (we && grp == G_NONE) |=> ($stable(eng_q) && $stable(irqc_q) && $stable(isrc_q)));
endmodule

// File: rtl/adcreg_bank.sv
`timescale 1ns/1ps
module adcreg_bank
  import adcreg_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NUM_CH = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         bus_wr,
  input  logic                         bus_rd,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [31:0]                  bus_wdata,
  output logic [31:0]                  bus_rdata,
  output logic                         bus_rvalid,
  output logic                         samp_req,
  output logic [$clog2(NUM_CH/2)-1:0]  samp_idx,
  output logic                         eng_on,
  output logic [2:0]                   eng_mode,
  output logic [NUM_CH-1:0]            chan_en
);
  localparam int CH_WORDS = NUM_CH / 2;
  localparam int IDX_W    = $clog2(NUM_CH);
  localparam int CIDX_W   = $clog2(CH_WORDS);

  grp_e              grp;
  logic [IDX_W-1:0]  idx;
  logic [31:0]       eng_q, irqc_q, det_q, clkc_q, isrc_q, trim_q;
  logic [31:0]       chan_rd, bnd_rd, hys_rd;
  logic [31:0]       scal_sel, scal_q;
  grp_e              rgrp_q;
  logic              rvalid_q, samp_q;
  logic [CIDX_W-1:0] sidx_q;

  adcreg_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_dec (
    .addr(bus_addr), .grp(grp), .idx(idx)
  );

  adcreg_ctlregs u_ctl (
    .clk(clk), .rst(rst), .we(bus_wr), .grp(grp), .wdata(bus_wdata),
    .eng_q(eng_q), .irqc_q(irqc_q), .det_q(det_q), .clkc_q(clkc_q),
    .isrc_q(isrc_q), .trim_q(trim_q)
  );

  adcreg_wordarray #(.DEPTH(CH_WORDS), .DATA_W(32), .MASK(MASK_PAIR)) u_chan (
    .clk(clk), .rst(rst), .we(bus_wr && grp == G_CHAN),
    .idx(idx[CIDX_W-1:0]), .wdata(bus_wdata), .rdata_q(chan_rd)
  );

  adcreg_wordarray #(.DEPTH(NUM_CH), .DATA_W(32), .MASK(MASK_PAIR)) u_bnd (
    .clk(clk), .rst(rst), .we(bus_wr && grp == G_BND),
    .idx(idx), .wdata(bus_wdata), .rdata_q(bnd_rd)
  );

  adcreg_wordarray #(.DEPTH(NUM_CH), .DATA_W(32), .MASK(MASK_HYS)) u_hys (
    .clk(clk), .rst(rst), .we(bus_wr && grp == G_HYS),
    .idx(idx), .wdata(bus_wdata), .rdata_q(hys_rd)
  );

  always_comb begin
    case (grp)
      G_ENG:   scal_sel = eng_q;
      G_IRQC:  scal_sel = irqc_q;
      G_DET:   scal_sel = det_q;
      G_CLKC:  scal_sel = clkc_q;
      G_ISRC:  scal_sel = isrc_q;
      G_TRIM:  scal_sel = trim_q;
      default: scal_sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q <= 1'b0;
      samp_q   <= 1'b0;
      sidx_q   <= '0;
      rgrp_q   <= G_NONE;
      scal_q   <= '0;
    end else begin
      rvalid_q <= bus_rd;
      samp_q   <= bus_rd && grp == G_CHAN;
      if (bus_rd) begin
        rgrp_q <= grp;
        scal_q <= scal_sel;
        sidx_q <= idx[CIDX_W-1:0];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rvalid_q) begin
      case (rgrp_q)
        G_CHAN:  bus_rdata = chan_rd;
        G_BND:   bus_rdata = bnd_rd;
        G_HYS:   bus_rdata = hys_rd;
        G_NONE:  bus_rdata = '0;
        default: bus_rdata = scal_q;
      endcase
    end
  end

  assign bus_rvalid = rvalid_q;
  assign samp_req   = samp_q;
  assign samp_idx   = sidx_q;
  assign eng_on     = eng_q[ENG_EN_BIT];
  assign eng_mode   = eng_q[3:1];
  assign chan_en    = eng_q[16 +: NUM_CH];

  p_rvalid_after_rd_r2: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);
  p_rvalid_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (!bus_rvalid && bus_rdata == '0));
  p_samp_with_read_r12: assert property (@(posedge clk) disable iff (rst)
    samp_req |-> bus_rvalid);
  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && grp == G_NONE) |=> (bus_rdata == '0));
endmodule

// File: tb/adcreg_bank_tb.sv
`timescale 1ns/1ps
module adcreg_bank_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, samp_req, eng_on;
  logic [2:0]  samp_idx, eng_mode;
  logic [15:0] chan_en;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [31:0] m_eng, m_irqc, m_det, m_clkc, m_isrc, m_trim;
  logic [31:0] m_chan [8];
  logic [31:0] m_bnd  [16];
  logic [31:0] m_hys  [16];

  always #4 clk = ~clk;

  adcreg_bank u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .samp_req(samp_req), .samp_idx(samp_idx), .eng_on(eng_on),
    .eng_mode(eng_mode), .chan_en(chan_en)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model_reset();
    m_eng = 0; m_irqc = 0; m_det = 32'hF; m_clkc = 32'hF; m_isrc = 0; m_trim = 0;
    for (int i = 0; i < 8; i++) m_chan[i] = 0;
    for (int i = 0; i < 16; i++) begin m_bnd[i] = 0; m_hys[i] = 0; end
  endfunction

  function automatic logic [31:0] exp_rd(logic [11:0] a);
    if (a[1:0] != 0) return 0;
    if (a == 12'h000) return m_eng;
    if (a == 12'h004) return m_irqc;
    if (a == 12'h008) return m_det;
    if (a == 12'h00C) return m_clkc;
    if (a == 12'h0C0) return m_isrc;
    if (a == 12'h0C4) return m_trim;
    if (a >= 12'h010 && a <= 12'h02C) return m_chan[(a - 12'h010) >> 2];
    if (a >= 12'h030 && a <= 12'h06C) return m_bnd[(a - 12'h030) >> 2];
    if (a >= 12'h070 && a <= 12'h0AC) return m_hys[(a - 12'h070) >> 2];
    return 0;
  endfunction

  function automatic void model_wr(logic [11:0] a, logic [31:0] d);
    logic [31:0] e;
    if (a[1:0] != 0) return;
    if (a == 12'h000) begin
      e = d; e[5] = 1'b0; e[8] = d[0]; m_eng = e;
    end else if (a == 12'h004) m_irqc = d;
    else if (a == 12'h008) m_det = d;
    else if (a == 12'h00C) m_clkc = d;
    else if (a == 12'h0C0) m_isrc = d & 32'h0000_FFFF;
    else if (a == 12'h0C4) m_trim = d & 32'h0000_000F;
    else if (a >= 12'h010 && a <= 12'h02C) m_chan[(a - 12'h010) >> 2] = d & 32'h03FF_03FF;
    else if (a >= 12'h030 && a <= 12'h06C) m_bnd[(a - 12'h030) >> 2] = d & 32'h03FF_03FF;
    else if (a >= 12'h070 && a <= 12'h0AC) m_hys[(a - 12'h070) >> 2] = d & 32'h83FF_03FF;
  endfunction

  function automatic bit is_chan(logic [11:0] a);
    return a[1:0] == 0 && a >= 12'h010 && a <= 12'h02C;
  endfunction

  task automatic bus_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    model_wr(a, d);
  endtask

  task automatic bus_read(logic [11:0] a, string req);
    logic [31:0] e;
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    e = exp_rd(a);
    @(negedge clk);
    bus_rd = 1'b0;
    chk(req, bus_rdata, e);
    chk("R2 rvalid", 32'(bus_rvalid), 32'd1);
    if (is_chan(a)) chk("R12 samp", {28'd0, samp_req, samp_idx}, {28'd0, 1'b1, 3'((a - 12'h010) >> 2)});
    else            chk("R12 no samp", 32'(samp_req), 32'd0);
  endtask

  task automatic collide(logic [11:0] a, logic [31:0] d);
    logic [31:0] e;
    @(negedge clk);
    bus_rd = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    e = exp_rd(a);
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    model_wr(a, d);
    chk("R13 old data", bus_rdata, e);
    bus_read(a, "R13 new data");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rvalid low", {30'd0, bus_rvalid, samp_req}, 32'd0);
    chk("R2 idle rdata", bus_rdata, 32'd0);
    for (int a = 0; a < 'hD0; a += 4) bus_read(12'(a), "R1 reset value");

    bus_write(12'h000, 32'h0000_0001);
    bus_read(12'h000, "R3 init follows enable");
    bus_write(12'h000, 32'hFFFF_FFFE);
    bus_read(12'h000, "R4 auto comp cleared");
    bus_write(12'h000, 32'hA5C3_0123);
    bus_read(12'h000, "R3 R4 mixed");
    chk("R5 fields", {11'd0, chan_en, eng_mode, eng_on}, {11'd0, 16'hA5C3, 3'd1, 1'b1});
    bus_write(12'h000, 32'h0000_000E);
    chk("R5 normal mode", {11'd0, chan_en, eng_mode, eng_on}, {11'd0, 16'h0000, 3'd7, 1'b0});

    bus_write(12'h004, 32'hDEAD_BEEF); bus_read(12'h004, "R6 irq ctrl");
    bus_write(12'h008, 32'hFFFF_FFFF); bus_read(12'h008, "R6 detect ctrl");
    bus_write(12'h00C, 32'h1234_5678); bus_read(12'h00C, "R6 clock ctrl");
    bus_write(12'h02C, 32'hFFFF_FFFF); bus_read(12'h02C, "R7 channel mask");
    bus_write(12'h010, 32'hFC00_FC01); bus_read(12'h010, "R7 channel low");
    bus_write(12'h06C, 32'hFFFF_FFFF); bus_read(12'h06C, "R8 bound mask");
    bus_write(12'h030, 32'h7FFF_7FFF); bus_read(12'h030, "R8 bound low");
    bus_write(12'h0AC, 32'hFFFF_FFFF); bus_read(12'h0AC, "R9 hyst mask");
    bus_write(12'h070, 32'h8000_0001); bus_read(12'h070, "R9 hyst enable");
    bus_write(12'h0C0, 32'hFFFF_FFFF); bus_read(12'h0C0, "R10 irq source");
    bus_write(12'h0C4, 32'hFFFF_FFFF); bus_read(12'h0C4, "R10 trim");
    bus_read(12'h01C, "R12 channel index");

    bus_write(12'h0B0, 32'hFFFF_FFFF);
    bus_write(12'h002, 32'hFFFF_FFFF);
    bus_write(12'h0C8, 32'hFFFF_FFFF);
    bus_write(12'hFFC, 32'hFFFF_FFFF);
    bus_write(12'h011, 32'hFFFF_FFFF);
    bus_read(12'h0B0, "R11 unmapped read");
    bus_read(12'h012, "R11 misaligned read");
    for (int a = 0; a < 'hD0; a += 4) bus_read(12'(a), "R11 no side effect");

    collide(12'h000, 32'h0000_0021);
    collide(12'h020, 32'hFFFF_FFFF);
    collide(12'h0A0, 32'h1357_9BDF);
    collide(12'h004, 32'h0F0F_0F0F);

    for (int n = 0; n < 600; n++) begin
      logic [11:0] a;
      logic [31:0] d;
      if ($urandom_range(0, 9) < 8) a = 12'($urandom_range(0, 'h33) * 4);
      else a = 12'($urandom);
      d = $urandom;
      case ($urandom_range(0, 4))
        0, 1:    bus_write(a, d);
        2, 3:    bus_read(a, "R7 R8 R9 random read");
        default: collide(a, d);
      endcase
    end

    @(negedge clk);
    chk("R2 rvalid drops", 32'(bus_rvalid), 32'd0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule